// File: doc/BRIEF.md
# Dual-Lane Halfword Saturating Multiply-Accumulator

This block is a two-lane SIMD multiply unit with a 64-bit accumulator held inside it. Each source operand is 64 bits wide and splits into two 32-bit lanes. From each lane the unit takes only the less significant halfword of each source and multiplies the two halfwords.

A 2-bit operation select chooses what happens to the product. The two signed modes add the product to the matching accumulator word, or subtract it, and clamp the result to the signed 32-bit range. The two unsigned modes write the raw 32-bit product; one of them also loads that product into the accumulator.

The 64-bit result is combinational and appears in the same cycle as the operands. The accumulator and the status flags update on the rising clock edge, and only while the valid strobe is high. There are two kinds of status flag, each one bit per lane. The overflow flags are rewritten by every signed operation. The sticky flags collect overflows until the next reset.

Top module: `hw_dual_mac`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to zero and clears both overflow flags and both sticky flags. These are all observed on the next clock edge.
- R2: The high lane (result bits [63:32]) multiplies source bits [47:32]. The low lane (result bits [31:0]) multiplies source bits [15:0]. Source bits [63:48] and [31:16] have no effect on any output.
- R3: With op_i = 2'b00 (signed accumulate), each lane's result is the accumulator word plus the signed 16x16 product, when that sum fits in a signed 32-bit value.
- R4: With op_i = 2'b01 (signed accumulate-negative), each lane's result is the accumulator word minus the signed product, when that difference fits in a signed 32-bit value.
- R5: In the signed modes, a lane whose exact sum or difference exceeds the signed 32-bit range outputs 32'h7FFF_FFFF for a positive excess and 32'h8000_0000 for a negative excess. Each lane saturates on its own.
- R6: A valid signed operation loads the 64-bit result into the accumulator. It sets ov_o[1] to the high-lane overflow and ov_o[0] to the low-lane overflow, clearing a bit when its lane did not overflow.
- R7: sov_o bits are ORed with ov_o on every valid signed operation. Only reset clears them.
- R8: With op_i = 2'b10 (unsigned modulo), each lane's result is the unsigned 32-bit product of its two halfwords. The accumulator, ov_o and sov_o keep their values.
- R9: With op_i = 2'b11 (unsigned modulo to accumulator), the result is the same unsigned product as in R8. It is also loaded into the accumulator, while ov_o and sov_o keep their values.
- R10: While vld_i is low, the accumulator, ov_o and sov_o keep their values. res_o still shows the combinational result.
- R11: In the signed modes, 16'h8000 times 16'h8000 gives the product 32'h4000_0000, with no overflow from the multiply itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Operation valid; enables accumulator and flag updates |
| op_i | input | 2 | Operation select: 00 signed add, 01 signed subtract, 10 unsigned, 11 unsigned to accumulator |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| res_o | output | 64 | Combinational result, high lane in [63:32] |
| acc_o | output | 64 | Registered accumulator |
| ov_o | output | 2 | Per-lane overflow of the last signed operation, bit 1 = high lane |
| sov_o | output | 2 | Per-lane sticky overflow, bit 1 = high lane |

## Verification
The bench builds the block with its default parameters: 16-bit elements and two lanes. This makes the whole signed-product range reachable, including 16'h8000 squared. Both 32-bit saturation limits can be hit exactly and exceeded by one.

The unsigned to-accumulator mode is used to plant accumulator values next to either limit in one lane while the other lane stays in range. This shows that each lane saturates and flags on its own. Garbage in the unused halfwords, and cycles with the strobe low, show that neither reaches the outputs or the state.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    typedef enum logic [1:0] {
        OP_SACC = 2'b00,
        OP_SNEG = 2'b01,
        OP_UMUL = 2'b10,
        OP_UACC = 2'b11
    } hmac_op_e;

    function automatic logic op_is_signed(input hmac_op_e op);
        return (op == OP_SACC) || (op == OP_SNEG);
    endfunction

    function automatic logic op_loads_acc(input hmac_op_e op);
        return op != OP_UMUL;
    endfunction

endpackage

// File: rtl/hmac_mul.sv
module hmac_mul #(
    parameter int EW = 16
) (
    input  logic [EW-1:0]   mul_a,
    input  logic [EW-1:0]   mul_b,
    input  logic            sgn,
    output logic [2*EW-1:0] prod
);
    localparam int PW = 2 * EW;

    logic signed [PW-1:0] prod_s;
    logic        [PW-1:0] prod_u;

    always_comb begin
        prod_s = $signed({{EW{mul_a[EW-1]}}, mul_a}) * $signed({{EW{mul_b[EW-1]}}, mul_b});
        prod_u = {{EW{1'b0}}, mul_a} * {{EW{1'b0}}, mul_b};
        prod   = sgn ? prod_s : prod_u;
    end
endmodule

// File: rtl/hmac_satadd.sv
module hmac_satadd #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_w,
    input  logic [W-1:0] prod_w,
    input  logic         neg,
    output logic [W-1:0] sum_w,
    output logic         ovf
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_acc;
    logic [W:0] ext_prod;
    logic [W:0] wide_d;

    always_comb begin
        ext_acc  = {acc_w[W-1], acc_w};
        ext_prod = {prod_w[W-1], prod_w};
        wide_d   = neg ? (ext_acc - ext_prod) : (ext_acc + ext_prod);
        // the two bits around the sign disagree only when the result left the range
        ovf      = wide_d[W] ^ wide_d[W-1];
        if (ovf) begin
            sum_w = wide_d[W] ? MIN_NEG : MAX_POS;
        end else begin
            sum_w = wide_d[W-1:0];
        end
    end
endmodule

// File: rtl/hmac_lane.sv
module hmac_lane
    import hmac_pkg::*;
#(
    parameter int EW = 16
) (
    input  hmac_op_e          op,
    input  logic [EW-1:0]     elem_a,
    input  logic [EW-1:0]     elem_b,
    input  logic [2*EW-1:0]   acc_w,
    output logic [2*EW-1:0]   res_w,
    output logic              ovf
);
    localparam int LW = 2 * EW;

    logic          sgn;
    logic [LW-1:0] prod;
    logic [LW-1:0] sat_sum;
    logic          sat_ovf;

    assign sgn = op_is_signed(op);

    hmac_mul #(.EW(EW)) u_mul (
        .mul_a (elem_a),
        .mul_b (elem_b),
        .sgn   (sgn),
        .prod  (prod)
    );

    hmac_satadd #(.W(LW)) u_sat (
        .acc_w  (acc_w),
        .prod_w (prod),
        .neg    (op == OP_SNEG),
        .sum_w  (sat_sum),
        .ovf    (sat_ovf)
    );

    always_comb begin
        res_w = sgn ? sat_sum : prod;
        ovf   = sgn & sat_ovf;
    end
endmodule

// File: rtl/hw_dual_mac.sv
module hw_dual_mac
    import hmac_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          vld_i,
    input  logic [1:0]                    op_i,
    input  logic [LANES*2*ELEM_W-1:0]     src_a_i,
    input  logic [LANES*2*ELEM_W-1:0]     src_b_i,
    output logic [LANES*2*ELEM_W-1:0]     res_o,
    output logic [LANES*2*ELEM_W-1:0]     acc_o,
    output logic [LANES-1:0]              ov_o,
    output logic [LANES-1:0]              sov_o
);
    localparam int LANE_W = 2 * ELEM_W;
    localparam int DATA_W = LANES * LANE_W;
    localparam logic [LANE_W-1:0] LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [LANES-1:0]  ov;
        logic [LANES-1:0]  sov;
    } mac_state_t;

    mac_state_t state_d, state_q;
    hmac_op_e   op_sel;
    logic [DATA_W-1:0] res_all;
    logic [LANES-1:0]  lane_ovf;

    assign op_sel = hmac_op_e'(op_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hmac_lane #(.EW(ELEM_W)) u_lane (
            .op     (op_sel),
            .elem_a (src_a_i[g*LANE_W +: ELEM_W]),
            .elem_b (src_b_i[g*LANE_W +: ELEM_W]),
            .acc_w  (state_q.acc[g*LANE_W +: LANE_W]),
            .res_w  (res_all[g*LANE_W +: LANE_W]),
            .ovf    (lane_ovf[g])
        );

        // R5: a flagged lane holds one of the two clamp values
        assert_sat_extreme_R5: assert property (@(posedge clk) disable iff (rst)
            (vld_i && !op_i[1]) |=> (!ov_o[g] ||
                acc_o[g*LANE_W +: LANE_W] == LANE_MAX ||
                acc_o[g*LANE_W +: LANE_W] == LANE_MIN));
    end

    always_comb begin
        state_d = state_q;
        if (vld_i) begin
            if (op_is_signed(op_sel)) begin
                state_d.acc = res_all;
                state_d.ov  = lane_ovf;
                state_d.sov = state_q.sov | lane_ovf;
            end else if (op_loads_acc(op_sel)) begin
                state_d.acc = res_all;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o = res_all;
    assign acc_o = state_q.acc;
    assign ov_o  = state_q.ov;
    assign sov_o = state_q.sov;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && ov_o == '0 && sov_o == '0));

    assert_signed_load_R6: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !op_i[1]) |=> (acc_o == $past(res_o)));

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sov_o & $past(sov_o)) == $past(sov_o)));

    assert_sticky_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !op_i[1]) |=> ((ov_o & ~sov_o) == '0));

    assert_unsigned_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i[1]) |=> ($stable(ov_o) && $stable(sov_o)));

    assert_plain_keeps_acc_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 2'b10) |=> $stable(acc_o));

    assert_uacc_load_R9: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 2'b11) |=> (acc_o == $past(res_o)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(acc_o) && $stable(ov_o) && $stable(sov_o)));
endmodule

// File: tb/sim_hw_dual_mac.sv
module sim_hw_dual_mac;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{2'd0, 64'h0000_0003_0000_0005, 64'h0000_0007_0000_FFFE},
        '{2'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_0001},
        '{2'd1, 64'h0000_0100_0000_8000, 64'h0000_0100_0000_0002},
        '{2'd2, 64'h0000_FFFF_0000_1234, 64'h0000_FFFF_0000_5678},
        '{2'd3, 64'h0000_7FFF_0000_8000, 64'h0000_7FFF_0000_8000},
        '{2'd0, 64'h0000_7FFF_0000_8000, 64'h0000_7FFF_0000_7FFF},
        '{2'd0, 64'h0000_7FFF_0000_8000, 64'h0000_7FFF_0000_7FFF},
        '{2'd1, 64'h0000_8000_0000_7FFF, 64'h0000_7FFF_0000_7FFF},
        '{2'd1, 64'hFFFF_8000_FFFF_7FFF, 64'hFFFF_7FFF_FFFF_7FFF},
        '{2'd2, 64'hAAAA_0001_5555_FFFF, 64'h1111_0001_2222_0002},
        '{2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{2'd1, 64'h0000_8000_0000_8000, 64'h0000_8000_0000_8000},
        '{2'd1, 64'h0000_8000_0000_8000, 64'h0000_8000_0000_8000},
        '{2'd0, 64'h0000_1234_0000_ABCD, 64'h0000_4321_0000_DCBA},
        '{2'd3, 64'h0000_C000_0000_0001, 64'h0000_0004_0000_0001},
        '{2'd0, 64'h0000_FFFF_0000_0001, 64'h0000_0001_0000_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        vld_i;
    logic [1:0]  op_i;
    logic [63:0] src_a_i, src_b_i, res_o, acc_o;
    logic [1:0]  ov_o, sov_o;

    int vec_cnt = 0;
    int bad_cnt = 0;

    logic [63:0] m_acc;
    logic [1:0]  m_ov, m_sov;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_dual_mac u0 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .res_o(res_o), .acc_o(acc_o), .ov_o(ov_o), .sov_o(sov_o)
    );

    // reference lane: {overflow, 32-bit result} from wide integer math
    function automatic logic [32:0] m_lane(input logic [1:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input logic [31:0] acc);
        longint p, s;
        logic [31:0] u;
        if (op[1]) begin
            u = {16'h0, a} * {16'h0, b};
            return {1'b0, u};
        end
        p = longint'($signed(a)) * longint'($signed(b));
        s = longint'($signed(acc));
        s = op[0] ? (s - p) : (s + p);
        if (s > 64'sd2147483647)       return {1'b1, 32'h7FFF_FFFF};
        else if (s < -64'sd2147483648) return {1'b1, 32'h8000_0000};
        else                           return {1'b0, s[31:0]};
    endfunction

    function automatic logic [63:0] pk(input logic [15:0] h, input logic [15:0] l);
        return {16'h0, h, 16'h0, l};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic apply(input string tag, input logic v, input logic [1:0] op,
                         input logic [63:0] a, input logic [63:0] b);
        logic [32:0] hi, lo;
        vld_i = v; op_i = op; src_a_i = a; src_b_i = b;
        hi = m_lane(op, a[47:32], b[47:32], m_acc[63:32]);
        lo = m_lane(op, a[15:0],  b[15:0],  m_acc[31:0]);
        #1;
        chk({tag, " result"}, res_o, {hi[31:0], lo[31:0]});
        if (v) begin
            if (!op[1]) begin
                m_acc = {hi[31:0], lo[31:0]};
                m_ov  = {hi[32], lo[32]};
                m_sov = m_sov | m_ov;
            end else if (op == 2'b11) begin
                m_acc = {hi[31:0], lo[31:0]};
            end
        end
        @(negedge clk);
        chk({tag, " acc"}, acc_o, m_acc);
        chk({tag, " flags"}, {60'h0, ov_o, sov_o}, {60'h0, m_ov, m_sov});
    endtask

    task automatic do_reset();
        rst = 1'b1; vld_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = '0; m_ov = '0; m_sov = '0;
        chk("R1 acc", acc_o, 64'h0);
        chk("R1 flags", {60'h0, ov_o, sov_o}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad_cnt++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        rst = 1'b1; vld_i = 1'b0; op_i = 2'b00; src_a_i = '0; src_b_i = '0;
        m_acc = '0; m_ov = '0; m_sov = '0;
        @(negedge clk);
        do_reset();

        // table walk, R3 R4 R8 R9 against the model
        foreach (TBL[i]) begin
            apply("R3/R4/R8/R9 table", 1'b1, TBL[i].op, TBL[i].a, TBL[i].b);
        end

        // R1: reset from a dirty state
        do_reset();

        // R11: most negative squared, then saturate upward in both lanes
        apply("R11", 1'b1, 2'b00, pk(16'h8000, 16'h8000), pk(16'h8000, 16'h8000));
        chk("R11 value", acc_o, 64'h4000_0000_4000_0000);
        chk("R11 no ovf", {62'h0, ov_o}, 64'h0);
        apply("R5 both", 1'b1, 2'b00, pk(16'h8000, 16'h8000), pk(16'h8000, 16'h8000));
        chk("R5 both high", acc_o, 64'h7FFF_FFFF_7FFF_FFFF);
        chk("R6 both ov", {62'h0, ov_o}, 64'h3);

        // planting near limits, lanes independent
        do_reset();
        apply("R9 plant", 1'b1, 2'b11, pk(16'h8000, 16'hFFFF), pk(16'hFFFF, 16'h8001));
        chk("R9 planted", acc_o, 64'h7FFF_8000_8000_7FFF);
        chk("R9 flags kept", {60'h0, ov_o, sov_o}, 64'h0);
        apply("R3 to max", 1'b1, 2'b00, pk(16'h7FFF, 16'h0000), pk(16'h0001, 16'h0000));
        chk("R3 exact max", acc_o, 64'h7FFF_FFFF_8000_7FFF);
        chk("R6 no ovf at max", {62'h0, ov_o}, 64'h0);
        apply("R5 high lane", 1'b1, 2'b00, pk(16'h0001, 16'h0000), pk(16'h0001, 16'h0000));
        chk("R5 high clamp", acc_o, 64'h7FFF_FFFF_8000_7FFF);
        chk("R6 high ov", {60'h0, ov_o, sov_o}, {60'h0, 2'b10, 2'b10});
        apply("R4 to min", 1'b1, 2'b01, pk(16'h0000, 16'h7FFF), pk(16'h0000, 16'h0001));
        chk("R4 exact min", acc_o, 64'h7FFF_FFFF_8000_0000);
        chk("R7 sticky kept", {60'h0, ov_o, sov_o}, {60'h0, 2'b00, 2'b10});
        apply("R5 low lane", 1'b1, 2'b01, pk(16'h0000, 16'h0001), pk(16'h0000, 16'h0001));
        chk("R5 low clamp", acc_o, 64'h7FFF_FFFF_8000_0000);
        chk("R7 sticky both", {60'h0, ov_o, sov_o}, {60'h0, 2'b01, 2'b11});

        // R8: unsigned leaves state
        apply("R8", 1'b1, 2'b10, pk(16'hFFFF, 16'h0003), pk(16'hFFFF, 16'h0005));
        chk("R8 product", res_o, 64'hFFFE_0001_0000_000F);
        chk("R8 acc kept", acc_o, 64'h7FFF_FFFF_8000_0000);
        chk("R8 flags kept", {60'h0, ov_o, sov_o}, {60'h0, 2'b01, 2'b11});

        // R10: strobe low
        apply("R10", 1'b0, 2'b11, pk(16'h1234, 16'h5678), pk(16'h0002, 16'h0003));
        chk("R10 acc kept", acc_o, 64'h7FFF_FFFF_8000_0000);

        // R2: junk in ignored halfwords
        apply("R2 junk", 1'b1, 2'b11, 64'hDEAD_0003_BEEF_0002, 64'hA5A5_0011_5A5A_0013);
        chk("R2 result", acc_o, 64'h0000_0033_0000_0026);

        // random mix against the model
        for (int k = 0; k < 400; k++) begin
            apply("R2/R3/R4/R5/R10 random", ($urandom % 8) != 0, 2'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule